// File: doc/BRIEF.md
# Segmented DAC Input Front End

This block is the digital side of an 8-bit segmented digital-to-analog converter. It takes a binary sample code, a complement control and an active-low latch enable. An XOR stage can invert the whole code. The code is then split into two fields. The three upper bits become a seven-line thermometer (bar-graph) code that selects equal-weight coarse segments. The five lower bits stay binary and drive the fine, binary-weighted part of the converter.

All twelve segment lines pass through one storage element before they reach the segment drivers. With the default style, this element is a level-sensitive transparent latch: it follows its input while the enable is low and freezes while the enable is high. A parameter replaces it with a clock-edge register for targets that cannot use latches. For checking, the block also rebuilds the integer that the latched segments stand for.

Top module: `dac_seg_frontend`

## Requirements
- R1: With `comp_i` low, bit n of `code_i` carries weight 2^n, and `code_o` equals `code_i` once that value has been latched.
- R2: With `comp_i` high, every bit of `code_i` is inverted before encoding, so `code_o` equals 255 minus `code_i` once latched.
- R3: `therm_o` bit k (k = 0..6) is 1 exactly when the latched upper 3-bit value (bits 7:5 after complement) is greater than k. Lines fill from bit 0 upward with no gaps.
- R4: `low_o` equals bits 4:0 of the (possibly complemented) code, with no re-coding.
- R5: While `le_n_i` is low, the segment outputs follow the input. In the default latch style this happens within the same cycle. In the register style the outputs take the new value at the next rising clock edge.
- R6: While `le_n_i` is high, `therm_o`, `low_o` and `code_o` keep their values whatever `code_i` and `comp_i` do.
- R7: `code_o` equals 32 times the number of set `therm_o` lines plus `low_o`, and always lies in 0..255.
- R8: While `rst` is high, all segment lines are held at 0, so `code_o` reads 0 until the first transparent phase after reset.
- R9: Alternating `le_n_i` between low and high on consecutive cycles captures the value present in each low cycle and holds it through the following high cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; used by the register style and by the checks |
| rst | input | 1 | Active-high reset; synchronous in the register style, level-acting in the latch style |
| code_i | input | 8 | Binary input code, high-true, bit 0 least significant |
| comp_i | input | 1 | 1 = invert every data bit before encoding |
| le_n_i | input | 1 | Latch enable, active low: 0 = transparent, 1 = hold |
| therm_o | output | 7 | Latched thermometer lines for the coarse segments |
| low_o | output | 5 | Latched binary lines for the fine segments |
| code_o | output | 8 | Integer value rebuilt from the latched segments |

## Verification
The bench walks through all 256 codes twice, once with the complement control low and once with it high. In the second pass it catches a missing or partial inversion, which would show up as the identity mapping or as a scrambled upper field. It compares every thermometer line on its own, so an encoder that is off by one, or that leaves a gap at the boundary values 0, 1, 6 and 7 of the upper field, is reported on the exact line it gets wrong. A hold phase changes the data and the complement control while the enable is high, and an alternating enable phase captures a new value every other cycle. Together these expose a latch with inverted enable polarity or one that leaks input through while it should hold. The reset check catches segments that come up with stale or undefined content.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;

    localparam int DEF_HI_W = 3;
    localparam int DEF_LO_W = 5;

    typedef enum logic {
        STORE_LEVEL = 1'b0,
        STORE_EDGE  = 1'b1
    } store_style_e;

    function automatic int therm_lines(input int hi_w);
        return (1 << hi_w) - 1;
    endfunction

endpackage

// File: rtl/dac_fe_therm_enc.sv
module dac_fe_therm_enc #(
    parameter int HI_W = 3,
    localparam int N = (1 << HI_W) - 1
) (
    input  logic [HI_W-1:0] hi_i,
    output logic [N-1:0]    therm_o
);
    for (genvar k = 0; k < N; k++) begin : g_line
        assign therm_o[k] = (int'(hi_i) > k);
    end
endmodule

// File: rtl/dac_fe_seg_store.sv
module dac_fe_seg_store
    import dac_fe_pkg::*;
#(
    parameter int           W     = 12,
    parameter store_style_e STYLE = STORE_LEVEL
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         le_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    if (STYLE == STORE_LEVEL) begin : g_level
        always_latch begin
            if (rst)
                q <= '0;
            else if (!le_n)
                q <= d;
        end
    end else begin : g_edge
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (!le_n)
                q <= d;
        end
    end
endmodule

// File: rtl/dac_fe_code_rebuild.sv
module dac_fe_code_rebuild #(
    parameter int HI_W = 3,
    parameter int LO_W = 5,
    localparam int N = (1 << HI_W) - 1
) (
    input  logic [N-1:0]         therm_i,
    input  logic [LO_W-1:0]      low_i,
    output logic [HI_W+LO_W-1:0] code_o
);
    logic [HI_W-1:0] count;

    always_comb begin
        count = '0;
        for (int k = 0; k < N; k++)
            count = count + HI_W'(therm_i[k]);
    end

    assign code_o = {count, low_i};
endmodule

// File: rtl/dac_seg_frontend.sv
module dac_seg_frontend
    import dac_fe_pkg::*;
#(
    parameter int           HI_W  = DEF_HI_W,
    parameter int           LO_W  = DEF_LO_W,
    parameter store_style_e STYLE = STORE_LEVEL,
    localparam int DATA_W = HI_W + LO_W,
    localparam int N      = (1 << HI_W) - 1,
    localparam int SEG_W  = N + LO_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] code_i,
    input  logic              comp_i,
    input  logic              le_n_i,
    output logic [N-1:0]      therm_o,
    output logic [LO_W-1:0]   low_o,
    output logic [DATA_W-1:0] code_o
);
    logic [DATA_W-1:0] code_x;
    logic [N-1:0]      therm_d;
    logic [SEG_W-1:0]  seg_q;

    assign code_x = code_i ^ {DATA_W{comp_i}};

    dac_fe_therm_enc #(.HI_W(HI_W)) u_enc (
        .hi_i    (code_x[DATA_W-1:LO_W]),
        .therm_o (therm_d)
    );

    dac_fe_seg_store #(.W(SEG_W), .STYLE(STYLE)) u_store (
        .clk  (clk),
        .rst  (rst),
        .le_n (le_n_i),
        .d    ({therm_d, code_x[LO_W-1:0]}),
        .q    (seg_q)
    );

    assign therm_o = seg_q[SEG_W-1:LO_W];
    assign low_o   = seg_q[LO_W-1:0];

    dac_fe_code_rebuild #(.HI_W(HI_W), .LO_W(LO_W)) u_rebuild (
        .therm_i (therm_o),
        .low_i   (low_o),
        .code_o  (code_o)
    );

    // R3: thermometer lines fill from the bottom with no gaps
    p_therm_fill_r3: assert property (@(posedge clk)
        ((therm_o + N'(1)) & therm_o) == '0);

    // R6: outputs keep their value across a cycle with enable high
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (le_n_i && $past(le_n_i) && !$past(rst)) |-> $stable(code_o));

    if (STYLE == STORE_LEVEL) begin : g_chk_level
        // R5: transparent phase tracks the complemented input
        p_track_r5: assert property (@(posedge clk) disable iff (rst)
            !le_n_i |-> code_o == (code_i ^ {DATA_W{comp_i}}));
        // R8: reset clears the segments
        p_reset_r8: assert property (@(posedge clk)
            rst |-> code_o == '0);
    end else begin : g_chk_edge
        // R5: register style captures at the edge
        p_track_r5: assert property (@(posedge clk) disable iff (rst)
            (!$past(le_n_i) && !$past(rst)) |->
                code_o == ($past(code_i) ^ {DATA_W{$past(comp_i)}}));
        // R8: reset clears the segments
        p_reset_r8: assert property (@(posedge clk)
            rst |=> code_o == '0);
    end
endmodule

// File: tb/tb_dac_seg_frontend.sv
module tb_dac_seg_frontend;
    import dac_fe_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] code_i = 8'h00;
    logic       comp_i = 1'b0;
    logic       le_n_i = 1'b1;
    logic [6:0] therm_o;
    logic [4:0] low_o;
    logic [7:0] code_o;

    int n_tests = 0;
    int n_fail  = 0;
    int model_val = 0;

    always #10 clk = ~clk;

    dac_seg_frontend dut (
        .clk(clk), .rst(rst), .code_i(code_i), .comp_i(comp_i),
        .le_n_i(le_n_i), .therm_o(therm_o), .low_o(low_o), .code_o(code_o)
    );

    // Apply inputs at negedge, then sample 5 ns after the next rising edge.
    task automatic step(input logic r, input logic [7:0] d, input logic c,
                        input logic le, input string tag);
        logic [6:0] exp_t;
        int hi;
        @(negedge clk);
        rst = r; code_i = d; comp_i = c; le_n_i = le;
        @(posedge clk);
        #5;
        if (r) model_val = 0;
        else if (!le) model_val = c ? (255 - int'(d)) : int'(d);
        hi = model_val / 32;
        for (int k = 0; k < 7; k++) exp_t[k] = (hi > k);
        n_tests++;
        if (therm_o !== exp_t) begin
            n_fail++;
            $display("FAIL %s/R3 therm actual=%b expected=%b", tag, therm_o, exp_t);
        end else if (low_o !== 5'(model_val % 32)) begin
            n_fail++;
            $display("FAIL %s/R4 low actual=%0d expected=%0d", tag, low_o, model_val % 32);
        end else if (code_o !== 8'(model_val)) begin
            n_fail++;
            $display("FAIL %s/R7 code actual=%0d expected=%0d", tag, code_o, model_val);
        end
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R8: reset state, even with enable low and data present
        step(1'b1, 8'hA5, 1'b0, 1'b0, "R8");
        step(1'b1, 8'hFF, 1'b1, 1'b0, "R8");
        // R6 after reset: hold keeps zero
        step(1'b0, 8'h77, 1'b0, 1'b1, "R6");
        // R1 and R5: full sweep, no complement
        for (int v = 0; v < 256; v++) step(1'b0, 8'(v), 1'b0, 1'b0, "R1");
        // R2: full sweep with complement
        for (int v = 0; v < 256; v++) step(1'b0, 8'(v), 1'b1, 1'b0, "R2");
        // R5: capture a value, then R6: hold while data and comp change
        step(1'b0, 8'h9C, 1'b0, 1'b0, "R5");
        for (int v = 0; v < 64; v++) step(1'b0, 8'(v * 4 + 1), v[0], 1'b1, "R6");
        // R9: alternate enable every cycle with changing data
        for (int v = 0; v < 128; v++)
            step(1'b0, 8'(v * 37 + 11), v[2], v[0], "R9");
        // R8 again: reset mid-run clears held value
        step(1'b0, 8'hE3, 1'b0, 1'b0, "R5");
        step(1'b1, 8'hE3, 1'b0, 1'b1, "R8");
        step(1'b0, 8'h11, 1'b0, 1'b1, "R8");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule